// File: doc/BRIEF.md
# Programmable Test Pattern Generator

This block emits a serial test stream, one bit per enabled clock, for bit-error-rate measurements on a link. A 32-stage shift register can run in three ways. It can be a pseudo-random generator whose length point and tap point are chosen at run time. It can be a plain rotation of a programmed word of up to 32 bits. It can also run a fixed quasi-random signal source (QRSS) sequence, x^20 + x^17 + 1, in which long runs of zeros are clamped.

Software sets up the configuration inputs and then raises the load strobe. The generator takes the new settings on the clock edge where the strobe is first seen high. To load again, the strobe must go back low first. An inversion input complements the serial output on the fly. A clock enable paces the shifting.

Top module: `tpg_top`

## Requirements
- R1: Synchronous active-high reset sets every register stage to 1 and clears the strobe edge detector. It also selects the rotating-word mode with length index 31, so `dout` is 1 XOR `inv` after reset.
- R2: A new configuration is taken only on a clock edge where `load_req` is 1 and was 0 on the previous edge. Holding `load_req` high loads once. A load takes place whether `ce` is high or low, and the new pattern appears at `dout` right after that edge.
- R3: Stages are numbered 1 to 32. The length point is stage n = `cfg_len` + 1 and the tap point is stage y = `cfg_tap` + 1. `dout` shows stage n. On each edge with `ce` = 1, every stage takes the value of the stage below it, and the feedback bit enters stage 1.
- R4: With `cfg_rep` = 0, the feedback is stage n XOR stage y. For example, n = 7 and y = 6 gives a sequence of period 127 with 64 ones per period.
- R5: With `cfg_rep` = 1, the feedback is stage n alone and `cfg_tap` has no effect. The output repeats `cfg_word` bits n-1 down to 0 (bit 0 is the least significant bit).
- R6: On load, `cfg_word` bit i-1 goes into stage i. In pseudo-random mode, if word bits n-1..0 are all zero, every stage is set to 1 instead.
- R7: With `cfg_qrss` = 1 at load, n = 20 and y = 17 are used in pseudo-random mode. Every stage is set to 1, and `cfg_word`, `cfg_len`, `cfg_tap` and `cfg_rep` are ignored. The first 20 output bits after the load are therefore 1.
- R8: In QRSS mode, the output is forced to 1 whenever stages 19 down to 6 (the next fourteen bits to be output) are all zero. No run of zeros longer than 14 appears.
- R9: With `inv` = 1, `dout` is the complement of the generated bit. The input acts at once and is not latched.
- R10: With `ce` = 0 and no load, the register contents and `dout` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Shift enable |
| load_req | input | 1 | Load strobe; its rising edge takes the configuration |
| inv | input | 1 | Output inversion |
| cfg_qrss | input | 1 | Force the QRSS pattern |
| cfg_rep | input | 1 | 0 = pseudo-random, 1 = rotating word |
| cfg_len | input | 5 | Length index (n - 1) |
| cfg_tap | input | 5 | Tap index (y - 1) |
| cfg_word | input | 32 | Seed or repeating word |
| dout | output | 1 | Serial test data |

## Verification
The checker watches these properties on every cycle:
- no load happens while the strobe is held high;
- the register stays frozen while the enable is low;
- a pseudo-random or QRSS load never leaves a locked all-zero register;
- a QRSS stream never has more than fourteen zeros in a row;
- a change of `inv` alone flips the output.

Some behaviour can only be shown by the bench's scenarios. These cover:
- the exact bit order of the rotating word;
- the period and weight of a chosen polynomial;
- the fact that the tap and seed fields are ignored in their modes;
- agreement with an independent bit-level model under random configurations.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  localparam int TPG_W  = 32;
  localparam int TPG_FW = 5;

  typedef struct packed {
    logic              qrss;
    logic              rep;
    logic [TPG_FW-1:0] len_idx;
    logic [TPG_FW-1:0] tap_idx;
  } tpg_cfg_t;

  // Stage (idx+1), counted from 1, lives at vector bit idx.
  function automatic logic stage_at(input logic [TPG_W-1:0] st,
                                    input logic [TPG_FW-1:0] idx);
    return st[idx];
  endfunction

  function automatic logic feedback(input logic [TPG_W-1:0] st,
                                    input tpg_cfg_t cfg);
    if (cfg.rep) return stage_at(st, cfg.len_idx);
    return stage_at(st, cfg.len_idx) ^ stage_at(st, cfg.tap_idx);
  endfunction

  function automatic logic [TPG_W-1:0] low_mask(input logic [TPG_FW-1:0] idx);
    logic [TPG_W:0] m;
    m = ({{TPG_W{1'b0}}, 1'b1} << (idx + 1)) - 1'b1;
    return m[TPG_W-1:0];
  endfunction

  function automatic logic [TPG_W-1:0] seed_value(input logic [TPG_W-1:0] word,
                                                  input tpg_cfg_t cfg);
    if (cfg.qrss) return '1;
    if (!cfg.rep && ((word & low_mask(cfg.len_idx)) == '0)) return '1;
    return word;
  endfunction
endpackage

// File: rtl/tpg_load_ctrl.sv
module tpg_load_ctrl
  import tpg_pkg::*;
#(
  parameter int QRSS_LEN = 20,
  parameter int QRSS_TAP = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_req,
  input  logic              cfg_qrss,
  input  logic              cfg_rep,
  input  logic [TPG_FW-1:0] cfg_len,
  input  logic [TPG_FW-1:0] cfg_tap,
  output logic              load_fire,
  output tpg_cfg_t          cfg_next,
  output tpg_cfg_t          cfg_act
);
  localparam logic [TPG_FW-1:0] Q_LEN_IDX = TPG_FW'(QRSS_LEN - 1);
  localparam logic [TPG_FW-1:0] Q_TAP_IDX = TPG_FW'(QRSS_TAP - 1);
  localparam tpg_cfg_t RST_CFG = '{qrss: 1'b0, rep: 1'b1,
                                   len_idx: TPG_FW'(TPG_W - 1),
                                   tap_idx: '0};

  logic load_prev;

  assign load_fire = load_req & ~load_prev;

  always_comb begin
    if (cfg_qrss) begin
      cfg_next = '{qrss: 1'b1, rep: 1'b0, len_idx: Q_LEN_IDX, tap_idx: Q_TAP_IDX};
    end else begin
      cfg_next = '{qrss: 1'b0, rep: cfg_rep, len_idx: cfg_len, tap_idx: cfg_tap};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      load_prev <= 1'b0;
      cfg_act   <= RST_CFG;
    end else begin
      load_prev <= load_req;
      if (load_fire) cfg_act <= cfg_next;
    end
  end
endmodule

// File: rtl/tpg_shift.sv
module tpg_shift
  import tpg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic             load_fire,
  input  logic [TPG_W-1:0] load_word,
  input  tpg_cfg_t         cfg_act,
  output logic [TPG_W-1:0] state,
  output logic             fb_bit
);
  assign fb_bit = feedback(state, cfg_act);

  always_ff @(posedge clk) begin
    if (rst)            state <= '1;
    else if (load_fire) state <= load_word;
    else if (ce)        state <= {state[TPG_W-2:0], fb_bit};
  end
endmodule

// File: rtl/tpg_zclamp.sv
module tpg_zclamp
  import tpg_pkg::*;
#(
  parameter int QRSS_LEN = 20,
  parameter int ZRUN     = 14
) (
  input  logic [TPG_W-1:0] state,
  input  logic             qrss_on,
  output logic             force_one
);
  // Window of upcoming output bits: stages QRSS_LEN-1 down to QRSS_LEN-ZRUN.
  localparam int WIN_HI = QRSS_LEN - 2;
  localparam int WIN_LO = QRSS_LEN - ZRUN - 1;

  generate
    if (ZRUN > 0) begin : g_clamp
      assign force_one = qrss_on && (state[WIN_HI:WIN_LO] == '0);
    end else begin : g_none
      assign force_one = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/tpg_top.sv
module tpg_top
  import tpg_pkg::*;
#(
  parameter int QRSS_LEN = 20,
  parameter int QRSS_TAP = 17,
  parameter int ZRUN     = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              load_req,
  input  logic              inv,
  input  logic              cfg_qrss,
  input  logic              cfg_rep,
  input  logic [TPG_FW-1:0] cfg_len,
  input  logic [TPG_FW-1:0] cfg_tap,
  input  logic [TPG_W-1:0]  cfg_word,
  output logic              dout
);
  logic             load_fire;
  tpg_cfg_t         cfg_next;
  tpg_cfg_t         cfg_act;
  logic [TPG_W-1:0] load_word;
  logic [TPG_W-1:0] state_q;
  logic             fb_bit;
  logic             raw_bit;
  logic             force_one;
  logic             gen_bit;

  tpg_load_ctrl #(.QRSS_LEN(QRSS_LEN), .QRSS_TAP(QRSS_TAP)) u_load (
    .clk(clk), .rst(rst), .load_req(load_req),
    .cfg_qrss(cfg_qrss), .cfg_rep(cfg_rep), .cfg_len(cfg_len), .cfg_tap(cfg_tap),
    .load_fire(load_fire), .cfg_next(cfg_next), .cfg_act(cfg_act)
  );

  assign load_word = seed_value(cfg_word, cfg_next);

  tpg_shift u_shift (
    .clk(clk), .rst(rst), .ce(ce), .load_fire(load_fire),
    .load_word(load_word), .cfg_act(cfg_act), .state(state_q), .fb_bit(fb_bit)
  );

  tpg_zclamp #(.QRSS_LEN(QRSS_LEN), .ZRUN(ZRUN)) u_zclamp (
    .state(state_q), .qrss_on(cfg_act.qrss), .force_one(force_one)
  );

  assign raw_bit = stage_at(state_q, cfg_act.len_idx);
  assign gen_bit = raw_bit | force_one;
  assign dout    = gen_bit ^ inv;
endmodule

// File: rtl/tpg_chk.sv
module tpg_chk
  import tpg_pkg::*;
#(
  parameter int ZRUN = 14
) (
  input logic             clk,
  input logic             rst,
  input logic             ce,
  input logic             load_req,
  input logic             inv,
  input logic             cfg_qrss,
  input logic             cfg_rep,
  input logic             dout,
  input logic             load_fire,
  input tpg_cfg_t         act,
  input logic [TPG_W-1:0] state
);
  localparam int ZCW = $clog2(ZRUN + 2) + 1;
  localparam logic [ZCW-1:0] ZMAX = ZCW'(ZRUN + 1);

  logic [ZCW-1:0] zc;

  always_ff @(posedge clk) begin
    if (rst || load_fire || !act.qrss) zc <= '0;
    else if (ce) begin
      if (dout ^ inv)      zc <= '0;
      else if (zc != ZMAX) zc <= zc + 1'b1;
    end
  end

  assert_single_load_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(load_req) && load_req) |-> !load_fire);

  assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (!ce && !load_fire) |=> $stable(state));

  assert_no_lockup_R6: assert property (@(posedge clk) disable iff (rst)
    (load_fire && !cfg_qrss && !cfg_rep) |=> (state != '0));

  assert_qrss_seed_R7: assert property (@(posedge clk) disable iff (rst)
    (load_fire && cfg_qrss) |=> ((state == '1) && act.qrss));

  assert_zero_run_R8: assert property (@(posedge clk) disable iff (rst)
    act.qrss |-> (zc <= ZCW'(ZRUN)));

  assert_invert_flips_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (inv != $past(inv)) && $stable(state) && $stable(act))
      |-> (dout != $past(dout)));
endmodule

bind tpg_top tpg_chk #(.ZRUN(ZRUN)) u_chk (
  .clk(clk), .rst(rst), .ce(ce), .load_req(load_req), .inv(inv),
  .cfg_qrss(cfg_qrss), .cfg_rep(cfg_rep), .dout(dout),
  .load_fire(load_fire), .act(cfg_act), .state(state_q)
);

// File: tb/sim_tpg_top.sv
module sim_tpg_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce = 1'b0;
  logic        load_req = 1'b0;
  logic        inv = 1'b0;
  logic        cfg_qrss = 1'b0;
  logic        cfg_rep = 1'b0;
  logic [4:0]  cfg_len = '0;
  logic [4:0]  cfg_tap = '0;
  logic [31:0] cfg_word = '0;
  logic        dout;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // Bench model: stages 1..32
  logic m [1:32];
  int   mn, my;
  bit   mrep, mqrss, mprev;
  logic last_out;
  logic rec [0:511];

  always #10 clk = ~clk;

  tpg_top u0 (
    .clk(clk), .rst(rst), .ce(ce), .load_req(load_req), .inv(inv),
    .cfg_qrss(cfg_qrss), .cfg_rep(cfg_rep), .cfg_len(cfg_len), .cfg_tap(cfg_tap),
    .cfg_word(cfg_word), .dout(dout)
  );

  task automatic check(input string req, input logic got, input logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: dout=%0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic check_int(input string req, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic logic model_out();
    logic b;
    bit zero;
    b = m[mn];
    if (mqrss) begin
      zero = 1;
      for (int k = 20 - 14; k <= 19; k++) if (m[k]) zero = 0;
      if (zero) b = 1'b1;
    end
    return b ^ inv;
  endfunction

  task automatic model_reset();
    for (int i = 1; i <= 32; i++) m[i] = 1'b1;
    mn = 32; my = 1; mrep = 1; mqrss = 0; mprev = 0;
  endtask

  task automatic model_step();
    logic fb;
    bit allz;
    if (load_req && !mprev) begin
      if (cfg_qrss) begin
        mn = 20; my = 17; mrep = 0; mqrss = 1;
        for (int i = 1; i <= 32; i++) m[i] = 1'b1;
      end else begin
        mn = cfg_len + 1; my = cfg_tap + 1; mrep = cfg_rep; mqrss = 0;
        for (int i = 1; i <= 32; i++) m[i] = cfg_word[i-1];
        allz = 1;
        for (int i = 1; i <= mn; i++) if (m[i]) allz = 0;
        if (!mrep && allz) for (int i = 1; i <= 32; i++) m[i] = 1'b1;
      end
    end else if (ce) begin
      fb = mrep ? m[mn] : (m[mn] ^ m[my]);
      for (int i = 32; i >= 2; i--) m[i] = m[i-1];
      m[1] = fb;
    end
    mprev = load_req;
  endtask

  // One cycle: compare before the edge, step the model at the edge.
  task automatic tick(input string req);
    #2;
    last_out = dout;
    check(req, dout, model_out());
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic do_load(input bit q, input bit r, input int len, input int tap,
                         input logic [31:0] w);
    cfg_qrss = q; cfg_rep = r; cfg_len = 5'(len); cfg_tap = 5'(tap); cfg_word = w;
    load_req = 1'b1;
    tick("R2");
    load_req = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    int run, maxrun, ones;
    logic held;
    void'($urandom(32'h5eed_1234));
    model_reset();
    @(negedge clk);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    ce = 1'b1;
    // R1: reset state gives all ones on the output
    for (int k = 0; k < 40; k++) begin
      #2 check("R1", dout, 1'b1);
      tick("R1");
    end

    // R5: rotating word, n = 8, bits 7..0 of 0xA5 in order
    do_load(0, 1, 7, 3, 32'hFFFF_FFA5);
    for (int k = 0; k < 24; k++) begin
      #2 check("R5 word order", dout, cfg_word[7 - (k % 8)]);
      tick("R5");
    end
    // R5: tap has no effect - same word, different tap, same stream
    do_load(0, 1, 7, 20, 32'h0000_00A5);
    for (int k = 0; k < 24; k++) begin
      #2 check("R5 tap ignored", dout, cfg_word[7 - (k % 8)]);
      tick("R5");
    end

    // R4: n=7, y=6 -> period 127, 64 ones
    do_load(0, 0, 6, 5, 32'h0000_0001);
    for (int k = 0; k < 254; k++) begin
      tick("R4");
      rec[k] = last_out;
    end
    ones = 0;
    for (int k = 0; k < 127; k++) begin
      if (rec[k]) ones++;
      check("R4 period", rec[k + 127], rec[k]);
    end
    check_int("R4 weight", ones, 64);

    // R6: zero seed in low n bits (upper bits set) becomes all ones
    do_load(0, 0, 8, 4, 32'hFFFF_FE00);
    for (int k = 0; k < 9; k++) begin
      #2 check("R6 all-ones seed", dout, 1'b1);
      tick("R6");
    end

    // R7: QRSS ignores word; first 20 bits are one; two seeds give same stream
    do_load(1, 1, 3, 3, 32'h0000_0000);
    for (int k = 0; k < 64; k++) begin
      if (k < 20) begin #2 check("R7 leading ones", dout, 1'b1); end
      tick("R7");
      rec[k] = last_out;
    end
    do_load(1, 0, 9, 2, 32'h1234_5678);
    for (int k = 0; k < 64; k++) begin
      tick("R7");
      check("R7 seed ignored", last_out, rec[k]);
    end

    // R8: long QRSS run, zero runs never exceed 14
    do_load(1, 0, 0, 0, 32'h0);
    run = 0; maxrun = 0;
    for (int k = 0; k < 40000; k++) begin
      tick("R8");
      if (!last_out) begin run++; if (run > maxrun) maxrun = run; end
      else run = 0;
    end
    n_cmp++;
    if (maxrun > 14) begin
      n_bad++;
      $display("FAIL R8: max zero run %0d expected <= 14", maxrun);
    end

    // R2: strobe held high, config changed: no reload
    do_load(0, 0, 10, 6, 32'h0000_0ABC);
    load_req = 1'b1;
    tick("R2");
    cfg_rep = 1'b1; cfg_len = 5'd3; cfg_word = 32'h0;
    for (int k = 0; k < 30; k++) tick("R2 held");
    load_req = 1'b0;
    tick("R2");
    // R2: load while ce low
    ce = 1'b0;
    do_load(0, 1, 3, 0, 32'h0000_0006);
    for (int k = 0; k < 4; k++) begin
      #2 check("R2 load with ce low", dout, 1'b0);
      tick("R2");
    end
    ce = 1'b1;
    for (int k = 0; k < 8; k++) begin
      #2 check("R2 word 0110", dout, cfg_word[3 - (k % 4)]);
      tick("R2");
    end

    // R10: ce low freezes output
    do_load(0, 0, 6, 5, 32'h0000_0055);
    repeat (5) tick("R10");
    ce = 1'b0;
    #2 held = dout;
    for (int k = 0; k < 12; k++) begin
      #2 check("R10 frozen", dout, held);
      tick("R10");
    end
    ce = 1'b1;

    // R9: inversion toggles live
    for (int k = 0; k < 20; k++) begin
      ce = 1'b0;
      #2 held = dout;
      inv = ~inv;
      #1 check("R9 flip", dout, ~held);
      tick("R9");
    end
    inv = 1'b0;
    ce = 1'b1;

    // R3: random configurations against the model
    for (int t = 0; t < 40; t++) begin
      do_load(($urandom % 6) == 0, $urandom % 2, $urandom % 32, $urandom % 32, $urandom);
      for (int k = 0; k < 200; k++) begin
        ce  = ($urandom % 4) != 0;
        inv = ($urandom % 8) == 0;
        load_req = ($urandom % 50) == 0;
        cfg_word = $urandom;
        tick("R3 random");
      end
      load_req = 1'b0;
      tick("R3");
    end

    finish_run();
  end
endmodule